// File: doc/BRIEF.md
# Patterned Bulk Byte-Copy Channel

This block is one channel of a byte-copy engine. It moves a run of bytes between a memory space and a small window of peripheral registers. The memory space is addressed by a 16-bit offset and a fixed 8-bit bank. The peripheral window sits at page 0x21 of bank zero. A start pulse latches a control byte, the memory offset and bank, a peripheral register index and a 16-bit byte count. The channel then runs the whole copy without pausing. It acts as a simple bus master, and each byte takes one read cycle followed by one write cycle.

On the peripheral side, the register touched for each byte is the latched index plus an offset. That offset comes from a short repeating pattern chosen by the mode field, so one run can feed register pairs or quads in a fixed order. On the memory side, only the 16-bit offset moves, and it moves up, down or not at all. When the run is over, the remaining count and the final memory offset stay readable.

Top module: `bulk_xfer_engine`

## Requirements
- R1: After reset the outputs are as follows: `busy`, `done`, `bus_rd` and `bus_wr` are low, and `remain_count` and `cur_addr` are zero.
- R2: Every byte takes two cycles: a cycle with `bus_rd` high, then a cycle with `bus_wr` high. The byte sampled on `bus_rdata` in the read cycle is driven on `bus_wdata` in the write cycle. `bus_rd` and `bus_wr` are never high together.
- R3: When control bit 7 is 0, the channel reads the memory side and writes the peripheral side. When it is 1, the channel reads the peripheral and writes memory.
- R4: The peripheral-side bus address is {8'h00, 8'h21, (index + pattern offset) mod 256}. The memory-side address is {bank, offset}.
- R5: Control bits 2:0 select the offset pattern, and the pattern repeats every byte. The patterns are: mode 0 gives {0}; mode 1 gives {0,1}; modes 2 and 6 give {0,0}; modes 3 and 7 give {0,0,1,1}; mode 4 gives {0,1,2,3}; mode 5 gives {0,1,0,1}. Each new run starts at the first entry of its pattern.
- R6: When control bit 3 is 0, the memory offset steps after each byte. It steps down by one when control bit 4 is 1 and up by one otherwise. The step wraps within 16 bits, and the bank is never changed.
- R7: When control bit 3 is 1, the memory offset stays fixed, whatever the value of bit 4.
- R8: The count drops by one per byte. The run ends when the count reaches zero, even partway through a pattern. After the run, `remain_count` reads 0 and `cur_addr` reads the final offset.
- R9: A byte count of 0 copies 65536 bytes.
- R10: `busy` rises in the cycle after an accepted start. It falls in the cycle after the last write, and in that same cycle `done` is high for exactly one cycle.
- R11: A start pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches a run when idle |
| ctrl | input | 8 | Control byte: bit 7 direction, bit 4 step down, bit 3 fixed offset, bits 2:0 mode |
| mem_addr | input | 16 | Starting memory offset |
| mem_bank | input | 8 | Memory bank for the whole run |
| reg_index | input | 8 | Base peripheral register index |
| byte_count | input | 16 | Bytes to copy (0 means 65536) |
| bus_addr | output | 24 | Bus address of the current access |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid in the read cycle |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse after the final write |
| remain_count | output | 16 | Bytes still to copy |
| cur_addr | output | 16 | Current memory offset |

## Verification
The embedded properties check the following on every cycle: the read/write alternation, that write data equals the byte read one cycle earlier, the single-step or held memory offset, the count falling by exactly one per byte, that the pattern index stays inside the active pattern, and that the latched control stays frozen while busy. Only the bench scenarios can show the full byte order of each mode, the choice of direction, the bank staying untouched across a 16-bit wrap, a run that stops partway through a pattern, the 65536-byte run for a zero count, and a second start being ignored.

// File: rtl/bxe_pkg.sv
// Package: shared types and mode-pattern decode for the bulk byte-copy channel.
// Assumes a 3-bit mode field and patterns of at most four entries.
package bxe_pkg;

    localparam int MODE_W    = 3;
    localparam int PAT_IDX_W = 2;
    localparam int PAT_LEN_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } bxe_state_t;

    typedef struct packed {
        logic              to_mem;   // bit 7: peripheral -> memory
        logic [1:0]        spare;    // bits 6:5: no function
        logic              step_dn;  // bit 4: step memory offset down
        logic              hold;     // bit 3: keep memory offset fixed
        logic [MODE_W-1:0] mode;     // bits 2:0: pattern select
    } bxe_ctrl_t;

    // Number of entries in the pattern picked by a mode.
    function automatic logic [PAT_LEN_W-1:0] pat_len(input logic [MODE_W-1:0] mode);
        case (mode)
            3'd0:       return 3'd1;
            3'd1:       return 3'd2;
            3'd2, 3'd6: return 3'd2;
            default:    return 3'd4;
        endcase
    endfunction

    // Register offset of a pattern entry.
    function automatic logic [PAT_IDX_W-1:0] pat_off(input logic [MODE_W-1:0] mode,
                                                      input logic [PAT_IDX_W-1:0] idx);
        case (mode)
            3'd1, 3'd5: return {1'b0, idx[0]};
            3'd3, 3'd7: return {1'b0, idx[1]};
            3'd4:       return idx;
            default:    return '0;
        endcase
    endfunction

endpackage

// File: rtl/bxe_pattern.sv
// Pattern walker: keeps the position inside the current mode's offset pattern
// and gives the register offset for the current byte.
// Assumes mode is held stable from restart until the run ends.
module bxe_pattern
    import bxe_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 advance,
    input  logic [MODE_W-1:0]    mode,
    output logic [PAT_IDX_W-1:0] offset
);

    logic [PAT_IDX_W-1:0] idx_q;
    logic [PAT_LEN_W-1:0] idx_next;

    assign idx_next = {1'b0, idx_q} + PAT_LEN_W'(1);

    // Move to the next pattern entry after each byte, wrapping at pattern length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (restart) begin
            idx_q <= '0;
        end else if (advance) begin
            if (idx_next >= pat_len(mode)) idx_q <= '0;
            else                           idx_q <= idx_next[PAT_IDX_W-1:0];
        end
    end

    // Turn the position into a register offset.
    always_comb begin
        offset = pat_off(mode, idx_q);
    end

    AST_PAT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, idx_q} < pat_len(mode)));  // R5

    AST_PAT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (idx_q == '0));  // R5

endmodule

// File: rtl/bxe_mem_addr.sv
// Memory offset register: loaded at launch, then stepped by one after each byte
// (up or down) unless hold is set. Only the offset moves; the bank lives outside.
module bxe_mem_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              step_dn,
    input  logic              hold,
    output logic [ADDR_W-1:0] addr
);

    logic [ADDR_W-1:0] addr_q;

    // Load at launch, step after each byte unless held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= load_val;
        end else if (step && !hold) begin
            if (step_dn) addr_q <= addr_q - ADDR_W'(1);
            else         addr_q <= addr_q + ADDR_W'(1);
        end
    end

    assign addr = addr_q;

    AST_ADDR_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hold && !step_dn && !load) |=> (addr_q - $past(addr_q) == ADDR_W'(1)));  // R6

    AST_ADDR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !hold && step_dn && !load) |=> ($past(addr_q) - addr_q == ADDR_W'(1)));  // R6

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (!step || hold)) |=> $stable(addr_q));  // R7

endmodule

// File: rtl/bxe_seq.sv
// Run sequencer: accepts a start when idle, alternates read and write cycles,
// counts bytes down (0 loads as 65536) and pulses done after the last write.
module bxe_seq
    import bxe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count_in,
    output logic             launch,
    output logic             rd_phase,
    output logic             wr_phase,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] remain
);

    localparam int CW1 = CNT_W + 1;

    bxe_state_t     state_q;
    logic [CW1-1:0] cnt_q;
    logic           done_q;
    logic           last_byte;

    assign launch    = start && (state_q == ST_IDLE);
    assign rd_phase  = (state_q == ST_RD);
    assign wr_phase  = (state_q == ST_WR);
    assign last_byte = (cnt_q == CW1'(1));

    // Step through idle, read and write; leave on the last write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (launch) state_q <= ST_RD;
                ST_RD:   state_q <= ST_WR;
                ST_WR:   state_q <= last_byte ? ST_IDLE : ST_RD;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Load the byte count (zero widened to the full span) and decrement per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (launch) begin
            cnt_q <= (count_in == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count_in};
        end else if (wr_phase) begin
            cnt_q <= cnt_q - CW1'(1);
        end
    end

    // One-cycle completion pulse after the final write.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= wr_phase && last_byte;
    end

    assign busy   = (state_q != ST_IDLE);
    assign done   = done_q;
    assign remain = cnt_q[CNT_W-1:0];

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_phase |=> ($past(cnt_q) - cnt_q == CW1'(1)));  // R8

    AST_CNT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q != '0));  // R9

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && cnt_q == '0));  // R10

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R10

endmodule

// File: rtl/bulk_xfer_engine.sv
// Bulk byte-copy channel top: latches the run setup at launch, steers each read
// and write to the memory side or to the peripheral window, and holds the read
// byte for the following write. Assumes bus_rdata is valid in the read cycle
// and that ADDR_W equals 8 plus REG_W.
module bulk_xfer_engine
    import bxe_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int BANK_W      = 8,
    parameter int REG_W       = 8,
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 16,
    parameter int PERIPH_PAGE = 8'h21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [7:0]               ctrl,
    input  logic [ADDR_W-1:0]        mem_addr,
    input  logic [BANK_W-1:0]        mem_bank,
    input  logic [REG_W-1:0]         reg_index,
    input  logic [CNT_W-1:0]         byte_count,
    output logic [BANK_W+ADDR_W-1:0] bus_addr,
    output logic                     bus_rd,
    output logic                     bus_wr,
    output logic [DATA_W-1:0]        bus_wdata,
    input  logic [DATA_W-1:0]        bus_rdata,
    output logic                     busy,
    output logic                     done,
    output logic [CNT_W-1:0]         remain_count,
    output logic [ADDR_W-1:0]        cur_addr
);

    localparam int BUS_W  = BANK_W + ADDR_W;
    localparam int PAGE_W = ADDR_W - REG_W;

    bxe_ctrl_t            ctrl_q;
    logic [BANK_W-1:0]    bank_q;
    logic [REG_W-1:0]     index_q;
    logic [DATA_W-1:0]    data_q;
    logic                 launch;
    logic                 rd_phase;
    logic                 wr_phase;
    logic [PAT_IDX_W-1:0] pat_offset;
    logic [ADDR_W-1:0]    offset_now;
    logic                 mem_side;
    logic [BUS_W-1:0]     mem_full;
    logic [BUS_W-1:0]     periph_full;

    bxe_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .count_in (byte_count),
        .launch   (launch),
        .rd_phase (rd_phase),
        .wr_phase (wr_phase),
        .busy     (busy),
        .done     (done),
        .remain   (remain_count)
    );

    bxe_pattern u_pattern (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (launch),
        .advance (wr_phase),
        .mode    (ctrl_q.mode),
        .offset  (pat_offset)
    );

    bxe_mem_addr #(.ADDR_W(ADDR_W)) u_mem_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (launch),
        .load_val (mem_addr),
        .step     (wr_phase),
        .step_dn  (ctrl_q.step_dn),
        .hold     (ctrl_q.hold),
        .addr     (offset_now)
    );

    // Latch the run setup when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            bank_q  <= '0;
            index_q <= '0;
        end else if (launch) begin
            ctrl_q  <= bxe_ctrl_t'(ctrl);
            bank_q  <= mem_bank;
            index_q <= reg_index;
        end
    end

    // Capture the byte read so it can be written in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_q <= '0;
        else if (rd_phase) data_q <= bus_rdata;
    end

    // Pick the side of each access and form both bus addresses.
    always_comb begin
        mem_side    = rd_phase ? !ctrl_q.to_mem : ctrl_q.to_mem;
        mem_full    = {bank_q, offset_now};
        periph_full = {{BANK_W{1'b0}}, PAGE_W'(PERIPH_PAGE), index_q + REG_W'(pat_offset)};
        bus_addr    = (rd_phase || wr_phase) ? (mem_side ? mem_full : periph_full) : '0;
    end

    assign bus_rd    = rd_phase;
    assign bus_wr    = wr_phase;
    assign bus_wdata = data_q;
    assign cur_addr  = offset_now;

    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));  // R2

    AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> $past(bus_rd));  // R2

    AST_WDATA_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> (bus_wdata == $past(bus_rdata)));  // R2

    AST_SETUP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ctrl_q) && $stable(bank_q) && $stable(index_q)));  // R11

    AST_BANK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !ctrl_q.to_mem) |-> (bus_addr[BUS_W-1:ADDR_W] == bank_q));  // R6

endmodule

// File: tb/bulk_xfer_engine_bench.sv
module bulk_xfer_engine_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [7:0]  ctrl;
    logic [15:0] mem_addr;
    logic [7:0]  mem_bank;
    logic [7:0]  reg_index;
    logic [15:0] byte_count;
    logic [23:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        busy, done;
    logic [15:0] remain_count, cur_addr;

    always #2 clk = ~clk;

    bulk_xfer_engine u_bulk_xfer_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl),
        .mem_addr(mem_addr), .mem_bank(mem_bank), .reg_index(reg_index),
        .byte_count(byte_count), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .busy(busy), .done(done), .remain_count(remain_count), .cur_addr(cur_addr)
    );

    // Bus responder: every address returns a byte derived from the address.
    function automatic logic [7:0] bus_val(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction
    assign bus_rdata = bus_rd ? bus_val(bus_addr) : 8'h00;

    // Offset pattern from the R5 table.
    function automatic logic [1:0] exp_off(input logic [2:0] mode, input int k);
        case (mode)
            3'd0:       return 2'd0;
            3'd1:       return (k % 2 == 1) ? 2'd1 : 2'd0;
            3'd2, 3'd6: return 2'd0;
            3'd3, 3'd7: return (k % 4 >= 2) ? 2'd1 : 2'd0;
            3'd4:       return 2'(k % 4);
            default:    return (k % 2 == 1) ? 2'd1 : 2'd0;
        endcase
    endfunction

    int checks = 0;
    int errors = 0;
    int n_wr = 0;
    int n_rd = 0;
    int done_seen = 0;
    logic [23:0] wr_a [64];
    logic [7:0]  wr_d [64];
    logic [23:0] rd_a [64];

    // Bus monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (bus_wr) begin
            if (n_wr < 64) begin
                wr_a[n_wr] = bus_addr;
                wr_d[n_wr] = bus_wdata;
            end
            n_wr = n_wr + 1;
        end
        if (bus_rd) begin
            if (n_rd < 64) rd_a[n_rd] = bus_addr;
            n_rd = n_rd + 1;
        end
        if (done) done_seen = done_seen + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic launch_run(input logic [7:0] c, input logic [15:0] a, input logic [7:0] b,
                              input logic [7:0] ix, input logic [15:0] n);
        @(negedge clk);
        n_wr = 0; n_rd = 0; done_seen = 0;
        ctrl = c; mem_addr = a; mem_bank = b; reg_index = ix; byte_count = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        for (int t = 0; t < 140000 && done_seen == 0; t++) @(negedge clk);
        @(negedge clk);
    endtask

    // Compare the recorded bytes with the expected order (R2..R7).
    task automatic verify_bytes(input logic [7:0] c, input logic [15:0] a, input logic [7:0] b,
                                input logic [7:0] ix, input int n);
        bit ok = 1'b1;
        logic [23:0] bad_act = '0, bad_exp = '0;
        for (int i = 0; i < n; i++) begin
            logic [15:0] m;
            logic [23:0] mfull, pfull, src, dst;
            if (c[3])      m = a;
            else if (c[4]) m = a - 16'(i);
            else           m = a + 16'(i);
            mfull = {b, m};
            pfull = {8'h00, 8'h21, ix + 8'(exp_off(c[2:0], i))};
            src = c[7] ? pfull : mfull;
            dst = c[7] ? mfull : pfull;
            if (ok && (rd_a[i] !== src || wr_a[i] !== dst || wr_d[i] !== bus_val(src))) begin
                ok = 1'b0;
                bad_act = (rd_a[i] !== src) ? rd_a[i] : wr_a[i];
                bad_exp = (rd_a[i] !== src) ? src : dst;
            end
        end
        check(ok, "R3 R4 R5 R6 R7", "byte order/address", 32'(bad_act), 32'(bad_exp));
    endtask

    // ctrl, start offset, bank, index, count, final offset
    localparam int NV = 8;
    localparam logic [71:0] VEC [NV] = '{
        {8'h00, 16'h1000, 8'h7E, 8'h18, 16'd3, 16'h1003},  // R5 mode 0, R6 up
        {8'h01, 16'h2000, 8'h01, 8'h18, 16'd5, 16'h2005},  // R5 mode 1, R8 mid-pattern stop
        {8'h13, 16'h0002, 8'h02, 8'h04, 16'd6, 16'hFFFC},  // R6 down with wrap, mode 3
        {8'h1C, 16'h4000, 8'h05, 8'h30, 16'd6, 16'h4000},  // R7 fixed beats down, mode 4
        {8'h85, 16'h5000, 8'h7F, 8'h22, 16'd4, 16'h5004},  // R3 to memory, mode 5
        {8'h82, 16'hFFFE, 8'h03, 8'h40, 16'd3, 16'h0001},  // R3 R6 up wrap, bank kept, mode 2
        {8'h07, 16'h6000, 8'h10, 8'hFF, 16'd4, 16'h6004},  // R4 index wrap, mode 7
        {8'h04, 16'h7000, 8'h11, 8'h50, 16'd1, 16'h7001}   // R8 single byte, mode 4
    };

    initial begin
        rst_n = 1'b0; start = 1'b0; ctrl = '0; mem_addr = '0; mem_bank = '0;
        reg_index = '0; byte_count = '0;
        repeat (3) @(negedge clk);

        // R1: state held in reset
        check(!busy && !done && !bus_rd && !bus_wr, "R1", "strobes in reset",
              {busy, done, bus_rd, bus_wr}, 0);
        check(remain_count == 0 && cur_addr == 0, "R1", "count/offset in reset",
              {remain_count, cur_addr}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [71:0] e;
            e = VEC[v];
            launch_run(e[71:64], e[63:48], e[47:40], e[39:32], e[31:16]);
            wait_done();
            verify_bytes(e[71:64], e[63:48], e[47:40], e[39:32], int'(e[31:16]));
            check(n_wr == int'(e[31:16]) && n_rd == n_wr, "R8", "byte count",
                  32'(n_wr), 32'(e[31:16]));
            check(cur_addr == e[15:0], "R6", "final offset", 32'(cur_addr), 32'(e[15:0]));
            check(remain_count == 0, "R8", "remaining count", 32'(remain_count), 0);
            check(done_seen == 1 && !busy, "R10", "single done pulse", 32'(done_seen), 1);
        end

        // R10 and R11: busy timing, and a second start ignored mid-run
        launch_run(8'h00, 16'h3000, 8'h10, 8'h10, 16'd4);
        check(busy == 1'b1, "R10", "busy after start", 32'(busy), 1);
        @(negedge clk);
        ctrl = 8'h8C; mem_addr = 16'h9000; mem_bank = 8'h44; reg_index = 8'h60;
        byte_count = 16'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        check(n_wr == 4, "R11", "bytes after ignored start", 32'(n_wr), 4);
        check(cur_addr == 16'h3004, "R11", "offset after ignored start", 32'(cur_addr), 32'h3004);
        verify_bytes(8'h00, 16'h3000, 8'h10, 8'h10, 4);
        check(!busy && done_seen == 1, "R10", "idle after run", 32'(done_seen), 1);

        // R9: a zero count copies 65536 bytes
        launch_run(8'h00, 16'h8000, 8'h20, 8'h00, 16'd0);
        wait_done();
        check(n_wr == 65536, "R9", "bytes for zero count", 32'(n_wr), 65536);
        check(cur_addr == 16'h8000, "R9", "offset after full wrap", 32'(cur_addr), 32'h8000);
        check(remain_count == 0 && !busy, "R9", "count after full run", 32'(remain_count), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (199000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule